// File: doc/BRIEF.md
# Single-Clock Queue with Newest-Entry Overwrite

This block is a single-clock first-in first-out queue. A producer pushes words through a write port guarded by a space flag. A consumer takes them from a read port guarded by a data-valid flag, and an occupancy count reports how many words are still waiting. A build-time switch picks one of two read styles. In the fall-through style the oldest word sits on the output with no request. In the registered style a read request fetches the oldest word into an output register, and that word appears one cycle later.

The queue also has an overwrite qualifier. When it is raised together with the write strobe, the input word replaces the most recently written word that is still unread, and nothing is appended. This suits producers that keep refining a pending item, such as a status word or a coalesced update, until the consumer takes it. Once that word has been taken, it is out of reach and the overwrite does nothing.

Top module: `lastfix_fifo`

## Requirements
- R1: After reset the occupancy count is 0, the space flag is 1 and the data-valid flag is 0 in both read styles.
- R2: The space flag is 1 exactly when the occupancy count is below DEPTH. A write strobe while it is 0 changes neither the count nor the stored words.
- R3: Words leave in the order they were appended.
- R4: The occupancy count equals the number of unread stored words. An append and a read in the same cycle, with the count between 1 and DEPTH-1, leave it unchanged.
- R5: Fall-through style (FWFT=1): the data-valid flag is 1 exactly when the count is non-zero, and the data output shows the oldest unread word with no request. A read request takes that word, and the next word is shown on the following cycle.
- R6: Registered style (FWFT=0): a read request while the count is non-zero sets the data-valid flag in the next cycle, with the oldest word on the data output. In a cycle after which no request was accepted, the data-valid flag is 0.
- R7: Write strobe plus overwrite qualifier, with a non-zero count, replaces the newest unread word with the input word. The count and the order of the other words are unchanged.
- R8: Write strobe plus overwrite qualifier with a count of 0 stores nothing, and the count stays 0.
- R9: An overwrite is carried out even when the queue is full, because it takes no space.
- R10: An overwrite in the same cycle as a read of the only stored word has no effect on the reader. The reader gets the old word, the count becomes 0 and the new word is dropped.
- R11: The overwrite qualifier without the write strobe has no effect.
- R12: A read request with a count of 0 has no effect. The count, the flags and the next word stored are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to append or to overwrite with |
| overwrite | input | 1 | Qualifies the write strobe as an overwrite of the newest unread word |
| wr_ready | output | 1 | Space available |
| rd_ack | input | 1 | Read request / consume |
| rd_data | output | DATA_W | Output word, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | Output word is valid |
| level | output | $clog2(DEPTH+1) | Count of unread stored words |

## Verification
The bench feeds the same stimulus to a fall-through instance and to a registered instance, both with a depth that is not a power of two, and follows them with a queue model. It goes after the overwrite corner cases. An overwrite on an empty queue that appends a word shows up as a later read of a word that was never written. An overwrite aimed at the wrong slot corrupts an older word. A design that lets an overwrite reach a word already being read hands the reader the new word. A design that gates the overwrite on free space fails to replace the word when the queue is full. The bench also checks a write strobe against a full queue, a read request against an empty one, and the wrap of the pointers past the non-power-of-two depth, any of which shows up as a wrong count or words out of order.

// File: rtl/lastfix_pkg.sv
package lastfix_pkg;
  // Width of an index into DEPTH slots (at least one bit).
  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Width of a counter that must hold DEPTH itself.
  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/lastfix_rst_sync.sv
module lastfix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lastfix_ptr_ctrl.sv
module lastfix_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             fix_req,
  input  logic             rd_req,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] fix_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             do_push,
  output logic             do_fix,
  output logic             do_pop
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] CAP      = LVL_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q,  level_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Qualification of the three operations against the current occupancy.
  always_comb begin
    full    = (level_q == CAP);
    empty   = (level_q == '0);
    do_push = wr_req & ~fix_req & ~full;
    do_fix  = wr_req &  fix_req & ~empty;
    do_pop  = rd_req & ~empty;
  end

  // Next-state for pointers and count.
  always_comb begin
    wr_ptr_d = do_push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({do_push, do_pop})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push)           wr_ptr_q <= wr_ptr_d;
      if (do_pop)            rd_ptr_q <= rd_ptr_d;
      if (do_push ^ do_pop)  level_q  <= level_d;
    end
  end

  // Slot of the newest word: one behind the write pointer, with wrap.
  always_comb begin
    fix_ptr = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - 1'b1;
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign level  = level_q;
endmodule

// File: rtl/lastfix_store.sv
module lastfix_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/lastfix_fifo.sv
module lastfix_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter bit FWFT   = 1'b1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic                                 overwrite,
  output logic                                 wr_ready,
  input  logic                                 rd_ack,
  output logic [DATA_W-1:0]                    rd_data,
  output logic                                 rd_valid,
  output logic [lastfix_pkg::cnt_width(DEPTH)-1:0] level
);
  localparam int PTR_W = lastfix_pkg::idx_width(DEPTH);
  localparam int LVL_W = lastfix_pkg::cnt_width(DEPTH);

  logic             rst_sync_n;
  logic [PTR_W-1:0] wr_ptr, fix_ptr, rd_ptr, waddr;
  logic             full, empty, do_push, do_fix, do_pop;
  logic [DATA_W-1:0] head;

  lastfix_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  lastfix_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_req  (wr_en),
    .fix_req (overwrite),
    .rd_req  (rd_ack),
    .wr_ptr  (wr_ptr),
    .fix_ptr (fix_ptr),
    .rd_ptr  (rd_ptr),
    .level   (level),
    .full    (full),
    .empty   (empty),
    .do_push (do_push),
    .do_fix  (do_fix),
    .do_pop  (do_pop)
  );

  assign waddr = do_fix ? fix_ptr : wr_ptr;

  lastfix_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk   (clk),
    .we    (do_push | do_fix),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (head)
  );

  assign wr_ready = ~full;

  generate
    if (FWFT) begin : g_fall_through
      assign rd_data  = head;
      assign rd_valid = ~empty;
    end else begin : g_registered
      logic              out_vld_q;
      logic [DATA_W-1:0] out_dat_q;

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          out_vld_q <= 1'b0;
          out_dat_q <= '0;
        end else begin
          out_vld_q <= do_pop;
          if (do_pop) out_dat_q <= head;
        end
      end

      assign rd_data  = out_dat_q;
      assign rd_valid = out_vld_q;
    end
  endgenerate
endmodule

// File: rtl/lastfix_fifo_chk.sv
module lastfix_fifo_chk #(
  parameter int DEPTH = 16,
  parameter bit FWFT  = 1'b1,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             overwrite,
  input logic             rd_ack,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic [LVL_W-1:0] level
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R4

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !overwrite && !wr_ready && !rd_ack) |=> level == $past(level)); // R2

  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !overwrite && wr_ready && !rd_ack) |=> level == $past(level) + 1'b1); // R4

  AST_POP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && level != '0 && !(wr_en && !overwrite)) |=> level == $past(level) - 1'b1); // R4

  AST_FIX_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && overwrite && !rd_ack) |=> $stable(level)); // R7

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && level == '0 && !wr_en) |=> level == '0); // R12

  generate
    if (FWFT) begin : g_ff
      AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (level != '0)); // R5
    end else begin : g_rg
      AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && level != '0) |=> rd_valid); // R6
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && level != '0) |=> !rd_valid); // R6
    end
  endgenerate
endmodule

bind lastfix_fifo lastfix_fifo_chk #(.DEPTH(DEPTH), .FWFT(FWFT), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .overwrite (overwrite),
  .rd_ack    (rd_ack),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .level     (level)
);

// File: tb/lastfix_fifo_bench.sv
module lastfix_fifo_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 5;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, overwrite = 1'b0, rd_ack = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_valid, nf_ready, nf_valid;
  logic [DW-1:0] rd_data, nf_data;
  logic [LW-1:0] level, nf_level;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int q[$];
  bit nf_v = 1'b0;
  int nf_d = 0;

  always #5 clk = ~clk;

  lastfix_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .FWFT(1'b1)) u_lastfix_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .overwrite(overwrite), .wr_ready(wr_ready), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_valid(rd_valid), .level(level));

  lastfix_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .FWFT(1'b0)) u_lastfix_fifo_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .overwrite(overwrite), .wr_ready(nf_ready), .rd_ack(rd_ack),
    .rd_data(nf_data), .rd_valid(nf_valid), .level(nf_level));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "level", int'(level), q.size());
    chk(tag, "writable", int'(wr_ready), int'(q.size() < DEPTH));
    chk(tag, "readable", int'(rd_valid), int'(q.size() > 0));
    if (q.size() > 0) chk(tag, "data", int'(rd_data), q[0]);
    chk({"R6 ", tag}, "reg level", int'(nf_level), q.size());
    chk({"R6 ", tag}, "reg readable", int'(nf_valid), int'(nf_v));
    if (nf_v) chk({"R6 ", tag}, "reg data", int'(nf_data), nf_d);
  endtask

  // One clock of stimulus on both instances, model update, then checks.
  task automatic step(input string tag, input bit w, input bit ov, input bit rd, input int d);
    int  n;
    bit  pop, fix, push;
    int  head;
    n    = q.size();
    pop  = rd && (n > 0);
    fix  = w && ov && (n > 0);
    push = w && !ov && (n < DEPTH);
    head = (n > 0) ? q[0] : 0;
    wr_en = w; overwrite = ov; rd_ack = rd; wr_data = DW'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; overwrite = 1'b0; rd_ack = 1'b0;
    if (fix)  q[n-1] = d;
    if (push) q.push_back(d);
    if (pop)  void'(q.pop_front());
    nf_v = pop;
    if (pop) nf_d = head;
    check_all(tag);
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) step(tag, 1'b0, 1'b0, 1'b1, 0);
    step(tag, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_reset;
    chk("R1", "level", int'(level), 0);
    chk("R1", "writable", int'(wr_ready), 1);
    chk("R1", "readable", int'(rd_valid), 0);
    chk("R1", "reg readable", int'(nf_valid), 0);
    chk("R1", "reg level", int'(nf_level), 0);
  endtask

  task automatic t_fill_and_overflow;
    for (int i = 0; i < DEPTH; i++) step("R3", 1'b1, 1'b0, 1'b0, 16 + i);
    chk("R2", "writable at full", int'(wr_ready), 0);
    step("R2", 1'b1, 1'b0, 1'b0, 8'hEE);
    drain("R5");
  endtask

  task automatic t_simultaneous;
    step("R4", 1'b1, 1'b0, 1'b0, 40);
    step("R4", 1'b1, 1'b0, 1'b0, 41);
    for (int i = 0; i < 6; i++) step("R4", 1'b1, 1'b0, 1'b1, 50 + i);
    drain("R3");
  endtask

  task automatic t_overwrite;
    step("R7", 1'b1, 1'b0, 1'b0, 60);
    step("R7", 1'b1, 1'b0, 1'b0, 61);
    step("R7", 1'b1, 1'b0, 1'b0, 62);
    step("R7", 1'b1, 1'b1, 1'b0, 99);
    step("R7", 1'b1, 1'b1, 1'b0, 98);
    drain("R7");
  endtask

  task automatic t_overwrite_empty;
    step("R8", 1'b1, 1'b1, 1'b0, 77);
    step("R8", 1'b1, 1'b0, 1'b0, 78);
    drain("R8");
  endtask

  task automatic t_overwrite_full;
    for (int i = 0; i < DEPTH; i++) step("R9", 1'b1, 1'b0, 1'b0, 100 + i);
    step("R9", 1'b1, 1'b1, 1'b0, 200);
    drain("R9");
  endtask

  task automatic t_overwrite_while_read;
    step("R10", 1'b1, 1'b0, 1'b0, 120);
    chk("R10", "head before", int'(rd_data), 120);
    step("R10", 1'b1, 1'b1, 1'b1, 121);
    step("R10", 1'b1, 1'b0, 1'b0, 122);
    drain("R10");
  endtask

  task automatic t_overwrite_no_write;
    step("R11", 1'b1, 1'b0, 1'b0, 130);
    step("R11", 1'b1, 1'b0, 1'b0, 131);
    step("R11", 1'b0, 1'b1, 1'b0, 222);
    drain("R11");
  endtask

  task automatic t_read_empty;
    step("R12", 1'b0, 1'b0, 1'b1, 0);
    step("R12", 1'b0, 1'b0, 1'b1, 0);
    step("R12", 1'b1, 1'b0, 1'b0, 140);
    drain("R12");
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_and_overflow();
    t_simultaneous();
    t_overwrite();
    t_overwrite_empty();
    t_overwrite_full();
    t_overwrite_while_read();
    t_overwrite_no_write();
    t_read_empty();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule